// File: doc/BRIEF.md
# Sigma-Delta ADC Sampler

This block is the digital half of a first-order sigma-delta analog-to-digital converter. A single comparator-style input watches an external RC-filtered node. The block registers that input on every clock and drives the inverse of the registered value back out on a feedback pin. The external network then integrates the feedback against the analog signal, so the density of ones on the input follows the analog level.

A free-running 32-bit tally counts the clocks on which the registered input was high. A window counter marks a sample point every `WINDOW` clocks. At each sample point the block publishes the tally minus the tally taken at the previous sample point, and then keeps the new tally as the base for the next window. `WINDOW` defaults to 2^`RES_BITS` − 1. For example, `RES_BITS` = 12 at 80 MHz gives roughly 19.5 kHz of output rate, and 8 gives roughly 313 kHz. `WINDOW` can also be set to a value that is not a power of two, such as 100, so that the result reads directly as a percentage.

`RES_BITS` must lie between 5 and 14, and `WINDOW` must be at least 2. Elaboration stops with an error otherwise. `CNT_INIT` sets the reset value of the tally. It does not change any result, and exists so that wraparound can be exercised.

Top module: `sd_adc_sampler`

## Requirements
- R1: The input is registered once. `fb_out` is the inverse of that registered bit. While reset is low, `fb_out` is 1 and `fb_oe` is 0. From the first clock after reset, `fb_oe` is 1.
- R2: The running tally grows by exactly one on each clock whose registered input is 1, and holds otherwise.
- R3: A sample point occurs every `WINDOW` clocks, first at the `WINDOW`-th clock edge after reset release. `sample_out` changes only at a sample point and holds between them.
- R4: At a sample point, `sample_out` becomes the current tally minus the tally captured at the previous sample point. This equals the number of ones the registered input held over the last `WINDOW` clocks.
- R5: The difference is taken modulo 2^32, so the result is unaffected by the tally wrapping past all-ones, whatever `CNT_INIT` is.
- R6: `sample_valid` is high for exactly one clock after each sample point. It stays low after the first sample point following reset, because that window has no known base.
- R7: With `WINDOW` = 100 and the input held high, each valid result is 100. A window length that is not a power of two works the same way as the default.
- R8: While reset is low, `sample_out` is 0 and `sample_valid` is 0. A reset in mid-run restarts the window timing and the first-result suppression.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sense_in | input | 1 | Comparator input from the filtered node |
| fb_out | output | 1 | Feedback drive, inverse of the registered input |
| fb_oe | output | 1 | Feedback output enable |
| sample_out | output | 32 | Ones counted over the last window |
| sample_valid | output | 1 | One-clock strobe marking a new valid result |

## Verification
An off-by-one in the window counter shows up as early as the second sample point. The strobe arrives one clock off, and the result then gains or loses a count. A tally or base register that goes wrong corrupts the very next valid result, because each result depends on both of them. A wrong registration stage on the input shows on `fb_out` within one clock. It also shifts which input clocks fall into each window, so patterns with transitions near a window boundary yield a different count. Wraparound errors appear only in an instance whose tally starts close to all-ones, so such an instance runs alongside the main one and must agree with it on every valid result.

// File: rtl/sd_adc_sampler.sv
module sd_adc_sampler #(
  parameter int RES_BITS = 5,
  parameter int WINDOW   = (1 << RES_BITS) - 1,
  parameter int CNT_W    = 32,
  parameter logic [CNT_W-1:0] CNT_INIT = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sense_in,
  output logic             fb_out,
  output logic             fb_oe,
  output logic [CNT_W-1:0] sample_out,
  output logic             sample_valid
);
  localparam int TICK_W = $clog2(WINDOW);
  localparam logic [TICK_W-1:0] LAST_TICK = TICK_W'(WINDOW - 1);

  if (RES_BITS < 5 || RES_BITS > 14) begin : g_bad_res
    $error("RES_BITS must lie in 5..14");
  end
  if (WINDOW < 2) begin : g_bad_win
    $error("WINDOW must be at least 2");
  end

  logic             in_q;
  logic             primed;
  logic [CNT_W-1:0] run_cnt;
  logic [CNT_W-1:0] base_cnt;
  logic [TICK_W-1:0] tick;
  logic             at_end;

  assign at_end = (tick == LAST_TICK);
  assign fb_out = ~in_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q         <= 1'b0;
      fb_oe        <= 1'b0;
      run_cnt      <= CNT_INIT;
      base_cnt     <= CNT_INIT;
      tick         <= '0;
      primed       <= 1'b0;
      sample_out   <= '0;
      sample_valid <= 1'b0;
    end else begin
      in_q         <= sense_in;
      fb_oe        <= 1'b1;
      run_cnt      <= run_cnt + CNT_W'(in_q);
      tick         <= at_end ? '0 : tick + 1'b1;
      sample_valid <= at_end && primed;
      if (at_end) begin
        sample_out <= run_cnt - base_cnt;
        base_cnt   <= run_cnt;
        primed     <= 1'b1;
      end
    end
  end

  assert_fb_inverse_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (fb_out == !$past(sense_in)));

  assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (run_cnt - $past(run_cnt) == CNT_W'($past(in_q))));

  assert_hold_between_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(at_end)) |-> $stable(sample_out));

  assert_one_clock_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sample_valid |=> !sample_valid);

  assert_strobe_after_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sample_valid) |-> ($past(at_end) && $past(primed)));
endmodule

// File: tb/sd_adc_sampler_bench.sv
module sd_adc_sampler_ref #(
  parameter int W = 31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sense,
  output logic        exp_fb,
  output logic [31:0] exp_val,
  output logic        exp_vld
);
  logic        d1;
  logic        seen;
  logic [31:0] win;
  int          t;
  assign exp_fb = !d1;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      d1 <= 1'b0; seen <= 1'b0; win <= '0; t <= 0; exp_val <= '0; exp_vld <= 1'b0;
    end else begin
      d1 <= sense;
      if (t == W - 1) begin
        t       <= 0;
        exp_val <= win;
        win     <= 32'(d1);
        exp_vld <= seen;
        seen    <= 1'b1;
      end else begin
        t       <= t + 1;
        win     <= win + 32'(d1);
        exp_vld <= 1'b0;
      end
    end
  end
endmodule

module sd_adc_sampler_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sense = 1'b0;
  int   errors = 0;
  int   checks = 0;
  bit   done = 1'b0;

  always #10 clk = ~clk;

  logic        fb_m, oe_m, vld_m, fb_p, oe_p, vld_p, fb_w, oe_w, vld_w;
  logic [31:0] out_m, out_p, out_w;
  logic        e_fb_m, e_vld_m, e_fb_p, e_vld_p;
  logic [31:0] e_val_m, e_val_p;

  sd_adc_sampler #(.RES_BITS(5)) u_sd_adc_sampler (
    .clk(clk), .rst_n(rst_n), .sense_in(sense), .fb_out(fb_m), .fb_oe(oe_m),
    .sample_out(out_m), .sample_valid(vld_m));
  sd_adc_sampler #(.RES_BITS(5), .WINDOW(100)) u_pct (
    .clk(clk), .rst_n(rst_n), .sense_in(sense), .fb_out(fb_p), .fb_oe(oe_p),
    .sample_out(out_p), .sample_valid(vld_p));
  sd_adc_sampler #(.RES_BITS(5), .CNT_INIT(32'hFFFF_FF00)) u_wrap (
    .clk(clk), .rst_n(rst_n), .sense_in(sense), .fb_out(fb_w), .fb_oe(oe_w),
    .sample_out(out_w), .sample_valid(vld_w));

  sd_adc_sampler_ref #(.W(31))  u_ref_m (.clk(clk), .rst_n(rst_n), .sense(sense),
    .exp_fb(e_fb_m), .exp_val(e_val_m), .exp_vld(e_vld_m));
  sd_adc_sampler_ref #(.W(100)) u_ref_p (.clk(clk), .rst_n(rst_n), .sense(sense),
    .exp_fb(e_fb_p), .exp_val(e_val_p), .exp_vld(e_vld_p));

  localparam int NPAT = 8;
  localparam logic [15:0] PAT [NPAT] = '{16'h0000, 16'hFFFF, 16'hAAAA, 16'h8888,
                                         16'h0F0F, 16'h0001, 16'hFFFE, 16'h1234};
  localparam int PAT_CYC [NPAT] = '{124, 124, 124, 93, 124, 155, 124, 217};

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step_check(input logic nxt);
    @(negedge clk);
    chk(fb_m == e_fb_m, "R1 fb_out", 32'(fb_m), 32'(e_fb_m));
    chk(oe_m == 1'b1, "R1 fb_oe", 32'(oe_m), 32'd1);
    chk(vld_m == e_vld_m, "R6 sample_valid", 32'(vld_m), 32'(e_vld_m));
    chk(out_m == e_val_m, "R3/R4 sample_out", out_m, e_val_m);
    chk(vld_p == e_vld_p, "R7 pct valid", 32'(vld_p), 32'(e_vld_p));
    if (vld_p) chk(out_p == e_val_p, "R7 pct result", out_p, e_val_p);
    if (vld_m) begin
      chk(out_m == e_val_m, "R2 tally", out_m, e_val_m);
      chk(vld_w && out_w == out_m, "R5 wrap", out_w, out_m);
    end
    sense = nxt;
  endtask

  task automatic reset_check();
    chk(fb_m == 1'b1 && fb_p == 1'b1 && fb_w == 1'b1, "R1 fb in reset", 32'(fb_m), 32'd1);
    chk(oe_m == 1'b0 && oe_p == 1'b0 && oe_w == 1'b0, "R1 oe in reset", 32'(oe_m), 32'd0);
    chk(out_m == 32'd0 && out_w == 32'd0 && out_p == 32'd0, "R8 out in reset", out_m, 32'd0);
    chk(!vld_m && !vld_p && !vld_w, "R8 valid in reset", 32'(vld_m), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    reset_check();
    rst_n = 1'b1;
    begin : table_walk
      int cyc = 0;
      for (int p = 0; p < NPAT; p++) begin
        for (int c = 0; c < PAT_CYC[p]; c++) begin
          step_check(PAT[p][cyc % 16]);
          cyc++;
        end
      end
    end
    // R7: long high stretch, percentage window reads 100
    begin : pct_full
      int seen100 = 0;
      for (int c = 0; c < 320; c++) begin
        step_check(1'b1);
        if (vld_p && out_p == 32'd100) seen100++;
      end
      chk(seen100 >= 2, "R7 full scale 100", 32'(seen100), 32'd2);
    end
    // R8: mid-run reset, then first strobe suppressed again
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    reset_check();
    @(negedge clk);
    rst_n = 1'b1;
    begin : restart
      int first = -1;
      int second = -1;
      for (int c = 1; c <= 70; c++) begin
        step_check(c[0]);
        if (vld_m && first < 0) first = c;
        else if (vld_m && second < 0) second = c;
      end
      chk(first == 62, "R8 R6 first valid after restart", 32'(first), 32'd62);
      chk(second == -1, "R3 strobe spacing", 32'(second), 32'hFFFF_FFFF);
    end
    // R2: input low everywhere gives zero
    for (int c = 0; c < 70; c++) step_check(1'b0);
    chk(out_m == 32'd0, "R2 no ones counts zero", out_m, 32'd0);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule